// File: doc/BRIEF.md
# Event Counter Monitor with Overflow Interrupt

This block counts events for an address-translation unit. It has four counters, each 32 bits wide. Each counter has its own configuration word. That word picks one of five event pulse inputs through a sparse 5-bit selector code, and it can arm an overflow interrupt for that counter. A shared control word holds three things: one master count enable, reset strobes that clear individual counters, and the polarity of the interrupt pin.

Software reaches the block over a plain register bus. The bus has an address, a write strobe, write data and read data. Reads are combinational. A write takes effect at the clock edge on which the strobe is high. Software can preload any counter with a value close to wrap. When a counter wraps it sets its own sticky flag in a shared status word, and software clears that flag by writing a one to it. The single interrupt output is asserted whenever a flagged counter also has its interrupt armed.

Top module: `evmon_top`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is high, because the polarity bit resets to 0 (active low) and no flag is set.
- R2: No counter advances while control bit 0 (master enable) is clear.
- R3: With the master enable set, a counter adds one on each clock in which its selected event input is high. Selector codes map to inputs as follows: 3 to `ev_pulse[0]`, 4 to `ev_pulse[1]`, 6 to `ev_pulse[2]`, 8 to `ev_pulse[3]` and 15 to `ev_pulse[4]`.
- R4: Selector code 0, and every code not listed in R3, counts nothing, whatever the event inputs do.
- R5: A bus write to a counter's value register loads that value, and it reads back unchanged.
- R6: A counter that steps from 0xFFFFFFFF wraps to 0, and the same edge sets status bit n for counter n (status bits 3:0).
- R7: Writing a one to a status bit clears that flag. Zero bits in the write data leave their flags unchanged.
- R8: When a write-one-to-clear and a new wrap of the same counter happen on the same edge, the flag stays set.
- R9: Writing a one to control bit 8+n clears counter n only. These bits do not store a value and always read as zero.
- R10: The interrupt is active when some counter has both its flag and its interrupt enable set. Control bit 2 sets the level: 1 means active high, 0 means active low.
- R11: The register map is: control at 0x00, status at 0x04, counter n at 0x40+4n, configuration n at 0x80+4n. In a configuration word, bit 0 is the interrupt enable and bits 6:2 are the selector. Control keeps only bits 0 and 2. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_pulse | input | 5 | Event pulse inputs |
| irq_o | output | 1 | Overflow interrupt, at the programmed level |

## Verification
The bench sets a clear and a new wrap of the same counter on one edge. A design in which the clear wins would drop the flag and lose an overflow. It steps a preloaded counter through 0xFFFFFFFF one pulse at a time. This catches a flag raised a cycle early, or a value that saturates instead of wrapping. It drives all event inputs against unmapped selector codes, which exposes a selector that decodes too widely. It also strobes one counter's reset bit and checks that the neighbours keep their values and that the bit reads back as zero.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

  localparam int SEL_W   = 5;
  localparam int NUM_SRC = 5;

  // Bit positions inside the control word
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_POL_BIT = 2;
  localparam int CTL_CLR_LSB = 8;

  // Bit positions inside a per-counter configuration word
  localparam int CFG_IE_BIT  = 0;
  localparam int CFG_SEL_LSB = 2;

  typedef struct packed {
    logic             irq_en;
    logic [SEL_W-1:0] sel;
  } cfg_t;

  typedef struct packed {
    logic       valid;
    logic [2:0] idx;
  } src_map_t;

  // Sparse selector: only five codes reach a real event input
  function automatic src_map_t map_code(input logic [SEL_W-1:0] code);
    src_map_t m;
    m = '{valid: 1'b0, idx: 3'd0};
    case (code)
      5'd3:  m = '{valid: 1'b1, idx: 3'd0};
      5'd4:  m = '{valid: 1'b1, idx: 3'd1};
      5'd6:  m = '{valid: 1'b1, idx: 3'd2};
      5'd8:  m = '{valid: 1'b1, idx: 3'd3};
      5'd15: m = '{valid: 1'b1, idx: 3'd4};
      default: m = '{valid: 1'b0, idx: 3'd0};
    endcase
    return m;
  endfunction

  function automatic cfg_t unpack_cfg(input logic [31:0] w);
    cfg_t c;
    c.irq_en = w[CFG_IE_BIT];
    c.sel    = w[CFG_SEL_LSB +: SEL_W];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(input cfg_t c);
    logic [31:0] w;
    w = '0;
    w[CFG_IE_BIT]              = c.irq_en;
    w[CFG_SEL_LSB +: SEL_W]    = c.sel;
    return w;
  endfunction

endpackage

// File: rtl/evmon_evsel.sv
module evmon_evsel
  import evmon_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic [SEL_W-1:0] code_i,
  input  logic [NSRC-1:0]  ev_i,
  output logic             hit_o
);

  src_map_t m;

  always_comb begin
    m     = map_code(code_i);
    hit_o = 1'b0;
    if (m.valid && (int'(m.idx) < NSRC))
      hit_o = ev_i[m.idx];
  end

endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  // Next value with the carry out in the top bit
  function automatic logic [W:0] step(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [W-1:0] cnt_q;
  logic [W:0]   sum;

  always_comb begin
    sum    = step(cnt_q);
    wrap_o = inc_i & ~clr_i & ~ld_i & sum[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (inc_i)  cnt_q <= sum[W-1:0];
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/evmon_irq.sv
module evmon_irq #(
  parameter int N = 4
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] ie_i,
  input  logic         pol_i,
  output logic         act_o,
  output logic         irq_o
);

  function automatic logic drive_level(input logic active, input logic high);
    return high ? active : ~active;
  endfunction

  assign act_o = |(flag_i & ie_i);
  assign irq_o = drive_level(act_o, pol_i);

endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 'h00,
  parameter int STAT_OFS = 'h04,
  parameter int CNT_BASE = 'h40,
  parameter int CFG_BASE = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] ev_pulse,
  output logic              irq_o
);

  localparam int STRIDE = 4;

  // Control state
  logic cnt_en;
  logic irq_pol;

  // Per-counter events brought out as named vectors
  logic [NUM_CNT-1:0] hit_v;
  logic [NUM_CNT-1:0] inc_v;
  logic [NUM_CNT-1:0] ld_v;
  logic [NUM_CNT-1:0] clr_v;
  logic [NUM_CNT-1:0] wrap_v;
  logic [NUM_CNT-1:0] cfg_we_v;
  logic [NUM_CNT-1:0] w1c_v;
  logic [NUM_CNT-1:0] flag_q;
  logic [NUM_CNT-1:0] ie_v;
  logic               irq_act;

  logic [CNT_W-1:0]         cnt_q  [NUM_CNT];
  cfg_t                     cfg_q  [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;

  logic ctrl_we, stat_we;

  assign ctrl_we = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
  assign stat_we = bus_we && (bus_addr == ADDR_W'(STAT_OFS));
  assign w1c_v   = stat_we ? bus_wdata[NUM_CNT-1:0] : '0;

  // Control register: only enable and polarity are stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en  <= 1'b0;
      irq_pol <= 1'b0;
    end else if (ctrl_we) begin
      cnt_en  <= bus_wdata[CTL_EN_BIT];
      irq_pol <= bus_wdata[CTL_POL_BIT];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(CNT_BASE + STRIDE*g);
      localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_BASE + STRIDE*g);

      assign ld_v[g]     = bus_we && (bus_addr == CNT_ADDR);
      assign cfg_we_v[g] = bus_we && (bus_addr == CFG_ADDR);
      assign clr_v[g]    = ctrl_we && bus_wdata[CTL_CLR_LSB + g];
      assign inc_v[g]    = cnt_en && hit_v[g];
      assign ie_v[g]     = cfg_q[g].irq_en;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cfg_q[g] <= '0;
        else if (cfg_we_v[g]) cfg_q[g] <= unpack_cfg(32'(bus_wdata));
      end

      evmon_evsel #(.NSRC(NUM_SRC)) u_sel (
        .code_i (cfg_q[g].sel),
        .ev_i   (ev_pulse),
        .hit_o  (hit_v[g])
      );

      evmon_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_v[g]),
        .ld_i     (ld_v[g]),
        .ld_val_i (CNT_W'(bus_wdata)),
        .inc_i    (inc_v[g]),
        .cnt_o    (cnt_q[g]),
        .wrap_o   (wrap_v[g])
      );

      assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];
    end
  endgenerate

  // Sticky overflow flags: a new wrap beats a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~w1c_v) | wrap_v;
  end

  evmon_irq #(.N(NUM_CNT)) u_irq (
    .flag_i (flag_q),
    .ie_i   (ie_v),
    .pol_i  (irq_pol),
    .act_o  (irq_act),
    .irq_o  (irq_o)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_OFS)) begin
      bus_rdata[CTL_EN_BIT]  = cnt_en;
      bus_rdata[CTL_POL_BIT] = irq_pol;
    end
    if (bus_addr == ADDR_W'(STAT_OFS))
      bus_rdata[NUM_CNT-1:0] = flag_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == ADDR_W'(CNT_BASE + STRIDE*i))
        bus_rdata = DATA_W'(cnt_q[i]);
      if (bus_addr == ADDR_W'(CFG_BASE + STRIDE*i))
        bus_rdata = DATA_W'(pack_cfg(cfg_q[i]));
    end
  end

endmodule

// File: rtl/evmon_chk.sv
module evmon_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cnt_en,
  input logic                     irq_pol,
  input logic                     irq_o,
  input logic [NUM_CNT-1:0]       inc_v,
  input logic [NUM_CNT-1:0]       ld_v,
  input logic [NUM_CNT-1:0]       clr_v,
  input logic [NUM_CNT-1:0]       wrap_v,
  input logic [NUM_CNT-1:0]       w1c_v,
  input logic [NUM_CNT-1:0]       flag_q,
  input logic [NUM_CNT-1:0]       ie_v,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

  a_r2_no_count_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && ld_v == '0 && clr_v == '0) |=> $stable(cnt_flat));

  a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ie_v) == '0) |-> (irq_o == !irq_pol));

  a_r10_active_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ie_v) != '0) |-> (irq_o == irq_pol));

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_p
      a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_v[g] && !ld_v[g] && !clr_v[g]) |=>
          (cnt_flat[g*CNT_W +: CNT_W] == CNT_W'($past(cnt_flat[g*CNT_W +: CNT_W]) + 1'b1)));

      a_r9_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_v[g] |=> (cnt_flat[g*CNT_W +: CNT_W] == '0));

      a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_v[g] |=> flag_q[g]);

      a_r7_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[g]) |-> $past(w1c_v[g]));
    end
  endgenerate

endmodule

bind evmon_top evmon_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_evmon_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .irq_pol  (irq_pol),
  .irq_o    (irq_o),
  .inc_v    (inc_v),
  .ld_v     (ld_v),
  .clr_v    (clr_v),
  .wrap_v   (wrap_v),
  .w1c_v    (w1c_v),
  .flag_q   (flag_q),
  .ie_v     (ie_v),
  .cnt_flat (cnt_flat)
);

// File: tb/test_evmon_top.sv
`timescale 1ns/1ps
module test_evmon_top;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  ev_pulse = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  evmon_top i_evmon_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse), .irq_o(irq_o)
  );

  function automatic logic [7:0] a_cnt(input int n); return 8'(8'h40 + 4*n); endfunction
  function automatic logic [7:0] a_cfg(input int n); return 8'(8'h80 + 4*n); endfunction
  function automatic logic [31:0] cfg_word(input int code, input bit ie);
    return (32'(code) << 2) | 32'(ie);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [4:0] m, input int n);
    @(negedge clk);
    ev_pulse = m;
    repeat (n) @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic t_reset;
    rd(A_CTRL, rv);   chk("R1 ctrl", rv, 0);
    rd(A_STAT, rv);   chk("R1 status", rv, 0);
    rd(a_cnt(0), rv); chk("R1 cnt0", rv, 0);
    rd(a_cfg(3), rv); chk("R1 cfg3", rv, 0);
    chk("R1 irq idle high", 32'(irq_o), 1);
  endtask

  task automatic t_disabled;
    wr(a_cfg(0), cfg_word(3, 0));
    pulse(5'b00001, 5);
    rd(a_cnt(0), rv); chk("R2 no count while disabled", rv, 0);
  endtask

  task automatic t_count;
    wr(A_CTRL, 32'hF01);
    wr(a_cfg(0), cfg_word(3, 0));
    wr(a_cfg(1), cfg_word(4, 0));
    wr(a_cfg(2), cfg_word(6, 0));
    wr(a_cfg(3), cfg_word(8, 0));
    pulse(5'b00001, 3);
    pulse(5'b00011, 2);
    pulse(5'b01110, 4);
    pulse(5'b10000, 2);
    rd(a_cnt(0), rv); chk("R3 code3", rv, 5);
    rd(a_cnt(1), rv); chk("R3 code4", rv, 6);
    rd(a_cnt(2), rv); chk("R3 code6", rv, 4);
    rd(a_cnt(3), rv); chk("R3 code8", rv, 4);
    wr(a_cfg(0), cfg_word(15, 0));
    pulse(5'b10000, 3);
    rd(a_cnt(0), rv); chk("R3 code15", rv, 8);
  endtask

  task automatic t_unmapped;
    wr(A_CTRL, 32'hF01);
    wr(a_cfg(0), cfg_word(0, 0));
    wr(a_cfg(1), cfg_word(5, 0));
    wr(a_cfg(2), cfg_word(31, 0));
    wr(a_cfg(3), cfg_word(7, 0));
    pulse(5'b11111, 4);
    for (int i = 0; i < 4; i++) begin
      rd(a_cnt(i), rv); chk("R4 unmapped code", rv, 0);
    end
  endtask

  task automatic t_map;
    wr(a_cnt(1), 32'h1234_5678);
    rd(a_cnt(1), rv); chk("R5 preload readback", rv, 32'h1234_5678);
    wr(a_cfg(2), 32'hFFFF_FFFF);
    rd(a_cfg(2), rv); chk("R11 cfg bits", rv, 32'h7D);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, rv); chk("R11 ctrl bits", rv, 32'h5);
    rd(a_cnt(1), rv); chk("R9 all strobes clear", rv, 0);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic t_wrap;
    wr(a_cfg(2), cfg_word(6, 0));
    wr(a_cnt(2), 32'hFFFF_FFFE);
    pulse(5'b00100, 1);
    rd(a_cnt(2), rv); chk("R6 at max", rv, 32'hFFFF_FFFF);
    rd(A_STAT, rv);   chk("R6 no early flag", rv, 0);
    pulse(5'b00100, 1);
    rd(a_cnt(2), rv); chk("R6 wrapped", rv, 0);
    rd(A_STAT, rv);   chk("R6 flag set", rv, 32'h4);
  endtask

  task automatic t_w1c;
    wr(A_STAT, 32'h0);
    rd(A_STAT, rv); chk("R7 zero write keeps", rv, 32'h4);
    wr(A_STAT, 32'hB);
    rd(A_STAT, rv); chk("R7 other bits keep", rv, 32'h4);
    wr(A_STAT, 32'h4);
    rd(A_STAT, rv); chk("R7 cleared", rv, 0);
  endtask

  task automatic t_collision;
    wr(a_cfg(3), cfg_word(8, 0));
    wr(a_cnt(3), 32'hFFFF_FFFF);
    pulse(5'b01000, 1);
    rd(A_STAT, rv); chk("R6 flag3", rv, 32'h8);
    wr(a_cnt(3), 32'hFFFF_FFFF);
    @(negedge clk);
    ev_pulse = 5'b01000; bus_addr = A_STAT; bus_wdata = 32'h8; bus_we = 1'b1;
    @(negedge clk);
    ev_pulse = '0; bus_we = 1'b0;
    rd(A_STAT, rv);   chk("R8 wrap beats clear", rv, 32'h8);
    rd(a_cnt(3), rv); chk("R8 counter wrapped", rv, 0);
  endtask

  task automatic t_rstbits;
    wr(a_cnt(0), 32'd10);
    wr(a_cnt(1), 32'd20);
    wr(a_cnt(2), 32'd30);
    wr(A_CTRL, 32'h201);
    rd(a_cnt(1), rv); chk("R9 target cleared", rv, 0);
    rd(a_cnt(0), rv); chk("R9 neighbour0 kept", rv, 10);
    rd(a_cnt(2), rv); chk("R9 neighbour2 kept", rv, 30);
    rd(A_CTRL, rv);   chk("R9 strobe reads zero", rv, 1);
  endtask

  task automatic t_irq;
    chk("R10 no enable, low-active idle", 32'(irq_o), 1);
    wr(a_cfg(3), cfg_word(8, 1));
    chk("R10 active low asserted", 32'(irq_o), 0);
    wr(A_CTRL, 32'h5);
    chk("R10 active high asserted", 32'(irq_o), 1);
    wr(a_cfg(0), cfg_word(3, 1));
    wr(A_STAT, 32'h8);
    chk("R10 active high idle", 32'(irq_o), 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_count();
    t_unmapped();
    t_map();
    t_wrap();
    t_w1c();
    t_collision();
    t_rstbits();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule